// File: doc/BRIEF.md
# Two-Write Four-Read Register File with XOR-Coded Banks

This block is a small register array for a datapath that needs several operands and up to two results in every clock cycle. It holds sixteen 32-bit words. It offers four read ports and two write ports, and all six can be used in the same cycle. Each write port owns one storage bank, and each bank has only one write port. A word is stored split across the two banks. The value a reader sees is the bitwise XOR of both banks at the read address.

A write on one port stores the new data XORed with the current word of the opposite bank at the same address. That opposite word comes from a dedicated extra read tap. Because of this, the plain XOR at read time always rebuilds the last value written, whichever port wrote it. No tracking table and no per-read-port selection are needed.

Reads are combinational. A write becomes visible after the clock edge that captures it. The caller must not send both ports to one address in the same cycle. The block flags that case on a dedicated output.

Top module: `xor_regfile`

## Requirements
- R1: Each of the four read ports returns, in the same cycle and without a clock edge, the word currently held at its own read address; the ports are independent and may share addresses.
- R2: A write on port A (enable high, reset input high) makes its data readable at its address on every read port from the cycle after the capturing clock edge.
- R3: A write on port B behaves as in R2, independently of port A.
- R4: Port A and port B writing two different addresses in the same cycle both take effect.
- R5: A read of an address that is being written in the same cycle returns the value held before that clock edge.
- R6: A write changes no address other than its own, and data presented with the enable low changes nothing.
- R7: The collision output is high exactly in cycles where both write enables are high and both write addresses are equal; the entry written in that cycle is then undefined.
- R8: From power-up every entry reads zero until it is written.
- R9: While the active-low reset input is low, both write enables are ignored and the contents are kept.
- R10: When ports A and B write one address in successive cycles, the address reads the most recent write, in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both write ports |
| rst_n | input | 1 | Active-low; while low, writes are blocked |
| wa_en | input | 1 | Write enable, port A |
| wa_addr | input | 4 | Write address, port A |
| wa_data | input | 32 | Write data, port A |
| wb_en | input | 1 | Write enable, port B |
| wb_addr | input | 4 | Write address, port B |
| wb_data | input | 32 | Write data, port B |
| rd_addr | input | 4x4 | Packed read addresses, one per read port |
| rd_data | output | 4x32 | Packed read data, one per read port |
| collide | output | 1 | Both ports target one address this cycle |

## Verification
The bench writes the same address from alternating ports in successive cycles. A design that encoded against the wrong bank, or against stale data, would return a mixture of bits there instead of the latest write. It reads an address during the same cycle it is being written, to catch a design that forwarded the new data early. It writes two different addresses at once while reading the neighbouring entries, which exposes an encoding tap pointed at the wrong address. It forces a collision and confirms the flag, and it checks that writes made while reset is low leave the power-up zeros in place.

// File: rtl/xrf_pkg.sv
package xrf_pkg;
    parameter int XRF_WIDTH = 32;
    parameter int XRF_DEPTH = 16;
    parameter int XRF_NREAD = 4;
endpackage

// File: rtl/xrf_bank.sv
module xrf_bank #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    parameter int NTAP  = 5,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic [NTAP-1:0][AW-1:0]    tap_addr,
    output logic [NTAP-1:0][WIDTH-1:0] tap_data
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
    } bank_state_t;

    bank_state_t state_q = '0;
    bank_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (wr_en && rst_n) begin
            state_d.mem[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        assign tap_data[t] = state_q.mem[tap_addr[t]];
    end

    // R2
    bank_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> state_q.mem[$past(wr_addr)] == $past(wr_data));

    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(state_q));
endmodule

// File: rtl/xrf_wenc.sv
module xrf_wenc #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] new_word,
    input  logic [WIDTH-1:0] other_bank_word,
    output logic [WIDTH-1:0] coded_word
);
    always_comb begin
        coded_word = new_word ^ other_bank_word;
    end
endmodule

// File: rtl/xrf_collide.sv
module xrf_collide #(
    parameter int AW = 4
) (
    input  logic          en_a,
    input  logic [AW-1:0] addr_a,
    input  logic          en_b,
    input  logic [AW-1:0] addr_b,
    output logic          hit
);
    always_comb begin
        hit = en_a && en_b && (addr_a == addr_b);
    end
endmodule

// File: rtl/xor_regfile.sv
module xor_regfile
    import xrf_pkg::*;
#(
    parameter int WIDTH = XRF_WIDTH,
    parameter int DEPTH = XRF_DEPTH,
    parameter int NREAD = XRF_NREAD,
    localparam int AW   = $clog2(DEPTH),
    localparam int NTAP = NREAD + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wa_en,
    input  logic [AW-1:0]               wa_addr,
    input  logic [WIDTH-1:0]            wa_data,
    input  logic                        wb_en,
    input  logic [AW-1:0]               wb_addr,
    input  logic [WIDTH-1:0]            wb_data,
    input  logic [NREAD-1:0][AW-1:0]    rd_addr,
    output logic [NREAD-1:0][WIDTH-1:0] rd_data,
    output logic                        collide
);
    logic [NTAP-1:0][AW-1:0]    a_taddr, b_taddr;
    logic [NTAP-1:0][WIDTH-1:0] a_tdata, b_tdata;
    logic [WIDTH-1:0]           a_coded, b_coded;

    // Last tap of each bank serves the opposite write port's encoding lookup.
    for (genvar r = 0; r < NREAD; r++) begin : g_rd
        assign a_taddr[r] = rd_addr[r];
        assign b_taddr[r] = rd_addr[r];
        assign rd_data[r] = a_tdata[r] ^ b_tdata[r];
    end
    assign a_taddr[NREAD] = wb_addr;
    assign b_taddr[NREAD] = wa_addr;

    xrf_wenc #(.WIDTH(WIDTH)) u_enc_a (
        .new_word(wa_data), .other_bank_word(b_tdata[NREAD]), .coded_word(a_coded));
    xrf_wenc #(.WIDTH(WIDTH)) u_enc_b (
        .new_word(wb_data), .other_bank_word(a_tdata[NREAD]), .coded_word(b_coded));

    xrf_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NTAP(NTAP)) u_bank_a (
        .clk(clk), .rst_n(rst_n), .wr_en(wa_en), .wr_addr(wa_addr), .wr_data(a_coded),
        .tap_addr(a_taddr), .tap_data(a_tdata));
    xrf_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NTAP(NTAP)) u_bank_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wb_en), .wr_addr(wb_addr), .wr_data(b_coded),
        .tap_addr(b_taddr), .tap_data(b_tdata));

    xrf_collide #(.AW(AW)) u_coll (
        .en_a(wa_en), .addr_a(wa_addr), .en_b(wb_en), .addr_b(wb_addr), .hit(collide));

    // R2
    port_a_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && !collide) |=>
        ((u_bank_a.state_q.mem[$past(wa_addr)] ^ u_bank_b.state_q.mem[$past(wa_addr)])
         == $past(wa_data)));

    // R3
    port_b_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !collide) |=>
        ((u_bank_a.state_q.mem[$past(wb_addr)] ^ u_bank_b.state_q.mem[$past(wb_addr)])
         == $past(wb_data)));
endmodule

// File: tb/xor_regfile_test.sv
module xor_regfile_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wa_en = 1'b0, wb_en = 1'b0;
    logic [3:0]        wa_addr = '0, wb_addr = '0;
    logic [31:0]       wa_data = '0, wb_data = '0;
    logic [3:0][3:0]   rd_addr = '0;
    logic [3:0][31:0]  rd_data;
    logic              collide;

    int errors = 0;
    int checks = 0;
    logic [31:0] model [16];
    bit          known [16];

    always #2 clk = ~clk;

    xor_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .collide(collide));

    function automatic logic exp_collide(logic ea, logic [3:0] aa, logic eb, logic [3:0] ab);
        return ea && eb && (aa == ab);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check combinational outputs, then commit the model.
    task automatic cycle(string tag, logic ea, logic [3:0] aa, logic [31:0] da,
                         logic eb, logic [3:0] ab, logic [31:0] db,
                         logic [3:0] r0, logic [3:0] r1, logic [3:0] r2, logic [3:0] r3);
        logic c;
        wa_en = ea; wa_addr = aa; wa_data = da;
        wb_en = eb; wb_addr = ab; wb_data = db;
        rd_addr[0] = r0; rd_addr[1] = r1; rd_addr[2] = r2; rd_addr[3] = r3;
        #1;
        c = exp_collide(ea, aa, eb, ab);
        chk({tag, " R7 collide"}, {31'd0, collide}, {31'd0, c});
        for (int p = 0; p < 4; p++) begin
            if (known[rd_addr[p]]) chk({tag, " R1 read"}, rd_data[p], model[rd_addr[p]]);
        end
        @(posedge clk);
        if (rst_n) begin
            if (c) begin
                known[aa] = 1'b0;
            end else begin
                if (ea) begin model[aa] = da; known[aa] = 1'b1; end
                if (eb) begin model[ab] = db; known[ab] = 1'b1; end
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [3:0]  a, b;
        logic [31:0] x, y;
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) begin model[i] = '0; known[i] = 1'b1; end
        @(negedge clk);
        // R9: writes with reset low must be ignored; R8: everything still zero
        cycle("R9", 1'b1, 4'd3, 32'hDEAD_BEEF, 1'b1, 4'd9, 32'h1234_5678, 0, 1, 2, 3);
        cycle("R9", 1'b1, 4'd0, 32'hFFFF_FFFF, 1'b0, 4'd0, 32'h0, 3, 9, 0, 15);
        rst_n = 1'b1;
        for (int g = 0; g < 4; g++)
            cycle("R8", 1'b0, 4'd0, 32'h0, 1'b0, 4'd0, 32'h0,
                  4'(4*g), 4'(4*g+1), 4'(4*g+2), 4'(4*g+3));
        // R6: data with enable low changes nothing
        cycle("R6", 1'b0, 4'd5, 32'hAAAA_AAAA, 1'b0, 4'd6, 32'h5555_5555, 5, 6, 5, 6);
        cycle("R6", 1'b0, 4'd0, 32'h0, 1'b0, 4'd0, 32'h0, 5, 6, 7, 4);
        // R2, R3, R4: dual write to distinct addresses, neighbours read
        cycle("R4", 1'b1, 4'd5, 32'h0BAD_F00D, 1'b1, 4'd6, 32'hC0DE_CAFE, 4, 5, 6, 7);
        cycle("R2", 1'b0, 4'd0, 32'h0, 1'b0, 4'd0, 32'h0, 5, 6, 4, 7);
        // R5: read during write to the same address sees the old value
        cycle("R5", 1'b1, 4'd5, 32'h1111_2222, 1'b1, 4'd6, 32'h3333_4444, 5, 6, 5, 6);
        cycle("R3", 1'b0, 4'd0, 32'h0, 1'b0, 4'd0, 32'h0, 5, 6, 5, 6);
        // R10: alternating ports on one address, both orders
        cycle("R10", 1'b1, 4'd12, 32'hA5A5_0001, 1'b0, 4'd0, 32'h0, 12, 12, 0, 1);
        cycle("R10", 1'b0, 4'd0, 32'h0, 1'b1, 4'd12, 32'h5A5A_0002, 12, 11, 13, 12);
        cycle("R10", 1'b1, 4'd12, 32'hFFFF_0003, 1'b0, 4'd0, 32'h0, 12, 12, 12, 12);
        cycle("R10", 1'b0, 4'd0, 32'h0, 1'b1, 4'd12, 32'h0000_0004, 12, 12, 12, 12);
        cycle("R10", 1'b0, 4'd0, 32'h0, 1'b0, 4'd0, 32'h0, 12, 12, 12, 12);
        // R7: forced collision, flag checked; entry then rewritten
        cycle("R7", 1'b1, 4'd8, 32'h1, 1'b1, 4'd8, 32'h2, 8, 7, 9, 0);
        cycle("R7", 1'b1, 4'd8, 32'h7777_8888, 1'b0, 4'd8, 32'h0, 7, 9, 0, 1);
        cycle("R7", 1'b0, 4'd8, 32'h0, 1'b1, 4'd8, 32'h0, 8, 8, 8, 8);
        // Random non-colliding dual writes with four random reads (R1, R2, R3, R4)
        for (int n = 0; n < 2000; n++) begin
            a = 4'($urandom);
            b = 4'($urandom);
            x = $urandom;
            y = $urandom;
            if (a == b) b = b + 4'd1;
            cycle("R1", 1'($urandom), a, x, 1'($urandom), b, y,
                  4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule